// File: doc/BRIEF.md
# Polynomial coefficient compressor and byte packer

This block turns polynomials of 256 coefficients, each a residue modulo 3329, into a dense byte stream. It fetches one coefficient per request from a synchronous RAM. It maps each coefficient to a d-bit symbol by scaled rounding and appends the symbols to a bit accumulator, lowest bit first. It writes each completed byte to an output byte RAM at the next sequential address.

A run is launched by a one-cycle start pulse. The start pulse carries three settings: the symbol width d (1 to 11), the number of polynomials, and a continue flag. With the continue flag set, the first byte of the new run lands right after the last byte of the previous run. This lets two regions of different widths sit back to back, for example a wide region of several polynomials followed by a single narrow one. The width d = 1 selects the message mode, which decides each bit by a plain range compare.

Top module: `coef_pack`

## Requirements
- R1: After reset no coefficient read, byte write or done pulse occurs, and the byte pointer is 0, so a run started with the continue flag set first writes address 0.
- R2: For d from 2 to 11 each coefficient x is mapped to round(x * 2^d / 3329) mod 2^d, with halves rounded up.
- R3: For d = 1 the symbol is 1 exactly when 832 < x <= 2496, otherwise 0.
- R4: Symbols form one bit stream in order of coefficient and then polynomial, each symbol lowest bit first; output byte j carries stream bits 8j to 8j+7, with stream bit 8j in byte bit 0.
- R5: A run of n polynomials reads each coefficient once, at address p*256 + i, for polynomial p from 0 to n-1 and index i from 0 to 255 in increasing order; the RAM returns data in the cycle after a read request.
- R6: A run writes exactly n*32*d bytes, one per write strobe, at strictly consecutive addresses.
- R7: With the continue flag clear the first byte of a run goes to address 0; with it set, the first byte goes to the address after the last byte of the previous run.
- R8: done is a single-cycle pulse in the cycle right after the final byte write of a run.
- R9: A start pulse is ignored while a run is in progress. It is also ignored when d is 0 or above 11, or when the polynomial count is 0 or above the maximum. An ignored start causes no read, no write and no pointer change.
- R10: The bit accumulator never holds more than 18 bits, and it is empty at every polynomial boundary, so each polynomial starts on a fresh byte.
- R11: d, the polynomial count and the continue flag are taken only at an accepted start; changing these inputs during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle run request |
| d_i | input | 4 | Symbol width, 1 to 11 |
| npoly_i | input | 3 | Polynomials in the run, 1 to MAX_POLY |
| cont_i | input | 1 | 1: continue output address from previous run; 0: restart at 0 |
| coef_rd_en_o | output | 1 | Coefficient RAM read request |
| coef_rd_addr_o | output | 10 | Coefficient RAM address, polynomial * 256 + index |
| coef_rd_data_i | input | 12 | Coefficient RAM data, valid the cycle after a request |
| byte_we_o | output | 1 | Output byte write strobe |
| byte_addr_o | output | 11 | Output byte address |
| byte_data_o | output | 8 | Output byte value |
| done_o | output | 1 | Run-complete pulse |

## Verification
The bench goes after the coefficients at the rounding and range edges (0, 832, 833, 1664, 1665, 2496, 2497, 3328). A wrong rounding direction or an off-by-one range compare would flip single symbols there. Widths 10 and 11 are run over several polynomials, and every width from 2 to 9 is covered, so symbols straddle byte edges in all alignments. An accumulator that mis-shifts a straddling symbol, or leaves bits over at a polynomial edge, corrupts every byte after the first fault. Back-to-back regions with the continue flag catch a pointer that resets or skips a byte. A restart after reset catches a pointer that was never cleared. A start pulse and changed settings in the middle of a run, plus illegal widths and counts, catch a controller that restarts or relatches. The exact done cycle is checked against the last write, which catches a done that fires while bits are still in flight.

// File: rtl/coef_pack_pkg.sv
`timescale 1ns/1ps
package coef_pack_pkg;
  localparam int unsigned Q      = 3329;
  localparam int unsigned N      = 256;
  localparam int unsigned N_LOG  = $clog2(N);
  localparam int unsigned COEF_W = 12;
  localparam int unsigned D_MAX  = 11;
  localparam int unsigned DW     = $clog2(D_MAX + 1);
  // leftover of at most 7 bits plus the widest symbol
  localparam int unsigned BUF_W  = 7 + D_MAX;
  localparam int unsigned CNT_W  = $clog2(BUF_W + 1);
  localparam int unsigned NUM_W  = COEF_W + D_MAX + 1;
  localparam int unsigned MSG_LO = Q / 4;
  localparam int unsigned MSG_HI = (3 * Q) / 4;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_FLUSH = 2'd2
  } pack_state_e;

  // round(x * 2^d / Q) mod 2^d; Q is odd so no exact half ever occurs
  function automatic logic [D_MAX-1:0] compress_coef(input logic [COEF_W-1:0] x,
                                                     input logic [DW-1:0] d);
    logic [NUM_W-1:0] num;
    logic [NUM_W-1:0] quo;
    logic [D_MAX-1:0] mask;
    num  = ({{(D_MAX + 1){1'b0}}, x} << d) + NUM_W'(Q / 2);
    quo  = num / NUM_W'(Q);
    mask = (D_MAX'(1) << d) - D_MAX'(1);
    return quo[D_MAX-1:0] & mask;
  endfunction

  // one-bit message decision: a range compare instead of a divide
  function automatic logic msg_bit(input logic [COEF_W-1:0] x);
    return (x > COEF_W'(MSG_LO)) && (x <= COEF_W'(MSG_HI));
  endfunction
endpackage

// File: rtl/cp_ctrl.sv
`timescale 1ns/1ps
module cp_ctrl import coef_pack_pkg::*; #(
  parameter int unsigned MAX_POLY = 4,
  localparam int unsigned NP_W = $clog2(MAX_POLY + 1),
  localparam int unsigned PA_W = (MAX_POLY > 1) ? $clog2(MAX_POLY) : 1,
  localparam int unsigned AW   = PA_W + N_LOG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [DW-1:0]   d_i,
  input  logic [NP_W-1:0] npoly_i,
  input  logic            cont_i,
  input  logic            data_pend_i,
  input  logic            sym_valid_i,
  input  logic            accum_empty_i,
  input  logic            byte_we_i,
  output logic            rd_en_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            rd_first_o,
  output logic [DW-1:0]   d_run_o,
  output logic            clr_ptr_o,
  output logic            done_o
);
  pack_state_e     st_q;
  logic [DW-1:0]   d_q;
  logic [NP_W-1:0] np_q;
  logic [AW-1:0]   idx_q;
  logic [NP_W-1:0] np_m1;
  logic [AW-1:0]   last_idx;
  logic            params_ok;
  logic            run_accept;
  logic            flush_done;
  logic            issue_now;

  assign params_ok  = (d_i != '0) && (d_i <= DW'(D_MAX)) &&
                      (npoly_i != '0) && (npoly_i <= NP_W'(MAX_POLY));
  assign run_accept = (st_q == S_IDLE) && start_i && params_ok;
  assign clr_ptr_o  = run_accept && !cont_i;
  assign np_m1      = np_q - NP_W'(1);
  assign last_idx   = {np_m1[PA_W-1:0], {N_LOG{1'b1}}};
  // one request every other cycle keeps the accumulator within BUF_W
  assign issue_now  = (st_q == S_ISSUE) && !rd_en_o;
  assign flush_done = (st_q == S_FLUSH) && !rd_en_o && !data_pend_i &&
                      !sym_valid_i && accum_empty_i;
  assign d_run_o    = d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      d_q        <= '0;
      np_q       <= '0;
      idx_q      <= '0;
      rd_en_o    <= 1'b0;
      rd_addr_o  <= '0;
      rd_first_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      rd_en_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (run_accept) begin
            st_q  <= S_ISSUE;
            d_q   <= d_i;
            np_q  <= npoly_i;
            idx_q <= '0;
          end
        end
        S_ISSUE: begin
          if (issue_now) begin
            rd_en_o    <= 1'b1;
            rd_addr_o  <= idx_q;
            rd_first_o <= (idx_q[N_LOG-1:0] == '0);
            idx_q      <= idx_q + AW'(1);
            if (idx_q == last_idx) st_q <= S_FLUSH;
          end
        end
        S_FLUSH: begin
          if (flush_done) begin
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_read_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(byte_we_i));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> !clr_ptr_o);
  p_width_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) && ($past(st_q) != S_IDLE) |-> $stable(d_run_o));
endmodule

// File: rtl/cp_compress.sv
`timescale 1ns/1ps
module cp_compress import coef_pack_pkg::*; #(
  parameter bit ONEBIT_CMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              first_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [DW-1:0]     d_i,
  output logic              data_pend_o,
  output logic              sym_valid_o,
  output logic [D_MAX-1:0]  sym_o,
  output logic              sym_first_o
);
  logic             req_q;
  logic             first_q;
  logic [D_MAX-1:0] sym_next;

  generate
    if (ONEBIT_CMP) begin : g_msg_cmp
      always_comb sym_next = (d_i == DW'(1)) ? D_MAX'(msg_bit(coef_i))
                                             : compress_coef(coef_i, d_i);
    end else begin : g_div_only
      always_comb sym_next = compress_coef(coef_i, d_i);
    end
  endgenerate

  assign data_pend_o = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q       <= 1'b0;
      first_q     <= 1'b0;
      sym_valid_o <= 1'b0;
      sym_o       <= '0;
      sym_first_o <= 1'b0;
    end else begin
      req_q       <= req_i;
      first_q     <= first_i;
      sym_valid_o <= req_q;
      if (req_q) begin
        sym_o       <= sym_next;
        sym_first_o <= first_q;
      end
    end
  end

  p_sym_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> ((sym_o >> d_i) == '0));
  p_msg_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o && (d_i == DW'(1)) |->
      sym_o[0] == (($past(coef_i) > COEF_W'(832)) && ($past(coef_i) <= COEF_W'(2496))));
endmodule

// File: rtl/cp_accum.sv
`timescale 1ns/1ps
module cp_accum import coef_pack_pkg::*; #(
  parameter int unsigned OUT_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_ptr_i,
  input  logic              sym_valid_i,
  input  logic [D_MAX-1:0]  sym_i,
  input  logic              sym_first_i,
  input  logic [DW-1:0]     d_i,
  output logic              empty_o,
  output logic              byte_we_o,
  output logic [OUT_AW-1:0] byte_addr_o,
  output logic [7:0]        byte_data_o
);
  logic [BUF_W-1:0]  buf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OUT_AW-1:0] ptr_q;
  logic              drain;
  logic [BUF_W-1:0]  base_buf;
  logic [CNT_W-1:0]  base_cnt;
  logic [BUF_W-1:0]  ins_bits;
  logic [CNT_W-1:0]  fill_cnt;

  assign drain    = cnt_q >= CNT_W'(8);
  assign base_buf = drain ? (buf_q >> 8) : buf_q;
  assign base_cnt = drain ? (cnt_q - CNT_W'(8)) : cnt_q;
  assign ins_bits = BUF_W'(sym_i) << base_cnt;
  assign fill_cnt = base_cnt + CNT_W'(d_i);
  assign empty_o  = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q       <= '0;
      cnt_q       <= '0;
      ptr_q       <= '0;
      byte_we_o   <= 1'b0;
      byte_addr_o <= '0;
      byte_data_o <= '0;
    end else begin
      byte_we_o <= drain;
      if (drain) begin
        byte_data_o <= buf_q[7:0];
        byte_addr_o <= ptr_q;
      end
      if (sym_valid_i) begin
        buf_q <= base_buf | ins_bits;
        cnt_q <= fill_cnt;
      end else begin
        buf_q <= base_buf;
        cnt_q <= base_cnt;
      end
      if (clr_ptr_i)  ptr_q <= '0;
      else if (drain) ptr_q <= ptr_q + OUT_AW'(1);
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_i |-> (fill_cnt <= CNT_W'(BUF_W)));
  p_poly_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_i && sym_first_i |-> (base_cnt == '0));
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we_o && $past(byte_we_o) |-> (byte_addr_o == $past(byte_addr_o) + OUT_AW'(1)));
endmodule

// File: rtl/coef_pack.sv
`timescale 1ns/1ps
module coef_pack import coef_pack_pkg::*; #(
  parameter int unsigned MAX_POLY   = 4,
  parameter int unsigned OUT_AW     = 11,
  parameter bit          ONEBIT_CMP = 1'b1,
  localparam int unsigned NP_W = $clog2(MAX_POLY + 1),
  localparam int unsigned AW   = ((MAX_POLY > 1) ? $clog2(MAX_POLY) : 1) + N_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DW-1:0]     d_i,
  input  logic [NP_W-1:0]   npoly_i,
  input  logic              cont_i,
  output logic              coef_rd_en_o,
  output logic [AW-1:0]     coef_rd_addr_o,
  input  logic [COEF_W-1:0] coef_rd_data_i,
  output logic              byte_we_o,
  output logic [OUT_AW-1:0] byte_addr_o,
  output logic [7:0]        byte_data_o,
  output logic              done_o
);
  logic             rd_first;
  logic [DW-1:0]    d_run;
  logic             clr_ptr;
  logic             data_pend;
  logic             sym_valid;
  logic [D_MAX-1:0] sym;
  logic             sym_first;
  logic             accum_empty;

  cp_ctrl #(.MAX_POLY(MAX_POLY)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .d_i           (d_i),
    .npoly_i       (npoly_i),
    .cont_i        (cont_i),
    .data_pend_i   (data_pend),
    .sym_valid_i   (sym_valid),
    .accum_empty_i (accum_empty),
    .byte_we_i     (byte_we_o),
    .rd_en_o       (coef_rd_en_o),
    .rd_addr_o     (coef_rd_addr_o),
    .rd_first_o    (rd_first),
    .d_run_o       (d_run),
    .clr_ptr_o     (clr_ptr),
    .done_o        (done_o)
  );

  cp_compress #(.ONEBIT_CMP(ONEBIT_CMP)) u_comp (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (coef_rd_en_o),
    .first_i     (rd_first),
    .coef_i      (coef_rd_data_i),
    .d_i         (d_run),
    .data_pend_o (data_pend),
    .sym_valid_o (sym_valid),
    .sym_o       (sym),
    .sym_first_o (sym_first)
  );

  cp_accum #(.OUT_AW(OUT_AW)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_ptr_i   (clr_ptr),
    .sym_valid_i (sym_valid),
    .sym_i       (sym),
    .sym_first_i (sym_first),
    .d_i         (d_run),
    .empty_o     (accum_empty),
    .byte_we_o   (byte_we_o),
    .byte_addr_o (byte_addr_o),
    .byte_data_o (byte_data_o)
  );
endmodule

// File: tb/coef_pack_tb.sv
`timescale 1ns/1ps
module coef_pack_tb;
  localparam int MAXP = 4;
  localparam int OAW  = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  d_i = '0;
  logic [2:0]  npoly_i = '0;
  logic        cont_i = 1'b0;
  logic        coef_rd_en_o;
  logic [9:0]  coef_rd_addr_o;
  logic [11:0] coef_rd_data_i = '0;
  logic        byte_we_o;
  logic [10:0] byte_addr_o;
  logic [7:0]  byte_data_o;
  logic        done_o;

  coef_pack #(.MAX_POLY(MAXP), .OUT_AW(OAW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .d_i(d_i), .npoly_i(npoly_i),
    .cont_i(cont_i), .coef_rd_en_o(coef_rd_en_o), .coef_rd_addr_o(coef_rd_addr_o),
    .coef_rd_data_i(coef_rd_data_i), .byte_we_o(byte_we_o), .byte_addr_o(byte_addr_o),
    .byte_data_o(byte_data_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  logic [11:0] coef_mem [0:1023];
  logic [7:0]  got      [0:2047];
  logic [7:0]  exp_b    [0:2047];

  always @(posedge clk) if (coef_rd_en_o) coef_rd_data_i <= coef_mem[coef_rd_addr_o];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int wr_cnt, first_addr, last_addr, addr_err, done_cnt, done_cyc, last_wr_cyc;
  int rd_cnt, rd_err;
  int next_ptr = 0;

  always @(negedge clk) begin
    if (byte_we_o) begin
      if (wr_cnt == 0) first_addr = int'(byte_addr_o);
      else if (int'(byte_addr_o) != last_addr + 1) addr_err++;
      last_addr = int'(byte_addr_o);
      got[byte_addr_o] = byte_data_o;
      wr_cnt++;
      last_wr_cyc = cyc;
    end
    if (coef_rd_en_o) begin
      if (int'(coef_rd_addr_o) != rd_cnt) rd_err++;
      rd_cnt++;
    end
    if (done_o) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int ref_comp(input int x, input int d);
    if (d == 1) return (x > 832 && x <= 2496) ? 1 : 0;
    return ((x * (1 << (d + 1)) + 3329) / 6658) % (1 << d);
  endfunction

  function automatic int edge_val(input int k);
    case (k)
      0: return 0;    1: return 3328; 2: return 832;  3: return 833;
      4: return 2496; 5: return 2497; 6: return 1664; default: return 1665;
    endcase
  endfunction

  task automatic clear_mon();
    wr_cnt = 0; addr_err = 0; done_cnt = 0; rd_cnt = 0; rd_err = 0;
    first_addr = -1; last_addr = -1; done_cyc = -1; last_wr_cyc = -100;
  endtask

  task automatic run_region(input int np, input int d, input bit cont,
                            input int seed, input bit disturb);
    int n, base, pos, mism, bad_a, bad_g, bad_e, waited, x, s;
    string tg;
    n = np * 32 * d;
    base = cont ? next_ptr : 0;
    for (int k = 0; k < np * 256; k++)
      coef_mem[k] = 12'((k * 1237 + seed * 911 + 17) % 3329);
    for (int k = 0; k < 8; k++) coef_mem[k] = 12'(edge_val(k));
    for (int j = 0; j < n; j++) exp_b[j] = 8'h00;
    pos = 0;
    for (int k = 0; k < np * 256; k++) begin
      x = int'(coef_mem[k]);
      s = ref_comp(x, d);
      for (int b = 0; b < d; b++) begin
        exp_b[pos / 8][pos % 8] = 1'((s >> b) & 1);
        pos++;
      end
    end
    clear_mon();
    @(negedge clk);
    start_i = 1'b1; d_i = 4'(d); npoly_i = 3'(np); cont_i = cont;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (done_cnt == 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (disturb && waited == 100) begin
        start_i = 1'b1; d_i = 4'd3; npoly_i = 3'd1; cont_i = ~cont;
      end else start_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    tg = disturb ? "R9 R11" : "R8";
    chk(done_cnt == 1, tg, "done pulse count", done_cnt, 1);
    chk(done_cyc == last_wr_cyc + 1, "R8", "done cycle after last write", done_cyc, last_wr_cyc + 1);
    chk(wr_cnt == n, "R6", "bytes written", wr_cnt, n);
    chk(addr_err == 0, "R6", "non-consecutive addresses", addr_err, 0);
    chk(first_addr == base, "R7", "first byte address", first_addr, base);
    chk(rd_cnt == np * 256 && rd_err == 0, "R5", "coefficient reads", rd_cnt - rd_err, np * 256);
    mism = 0; bad_a = -1; bad_g = 0; bad_e = 0;
    for (int j = 0; j < n; j++)
      if (got[(base + j) % 2048] !== exp_b[j]) begin
        if (mism == 0) begin bad_a = j; bad_g = int'(got[(base + j) % 2048]); bad_e = int'(exp_b[j]); end
        mism++;
      end
    if (d == 1) tg = "R3 R4";
    else if (np > 1) tg = "R2 R4 R10";
    else tg = "R2 R4";
    chk(mism == 0, tg, $sformatf("byte %0d of d=%0d region", bad_a, d), bad_g, bad_e);
    next_ptr = base + n;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!coef_rd_en_o && !byte_we_o && !done_o, "R1", "outputs in reset",
        int'({coef_rd_en_o, byte_we_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!coef_rd_en_o && !byte_we_o && !done_o, "R1", "outputs idle after reset",
        int'({coef_rd_en_o, byte_we_o, done_o}), 0);
  endtask

  task automatic t_illegal(input int d, input int np);
    clear_mon();
    @(negedge clk);
    start_i = 1'b1; d_i = 4'(d); npoly_i = 3'(np); cont_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    chk(wr_cnt == 0 && rd_cnt == 0 && done_cnt == 0, "R9",
        $sformatf("illegal start d=%0d n=%0d activity", d, np), wr_cnt + rd_cnt + done_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_mon();
    t_reset();
    run_region(2, 10, 1'b1, 1, 1'b0);   // R1: continue right after reset starts at 0
    run_region(1, 4, 1'b1, 2, 1'b0);    // R7: second region follows directly
    run_region(3, 10, 1'b0, 3, 1'b0);
    run_region(4, 11, 1'b0, 4, 1'b0);
    run_region(1, 5, 1'b1, 5, 1'b0);
    run_region(1, 1, 1'b0, 6, 1'b0);    // R3 message mode
    for (int d = 2; d <= 9; d++) run_region(1, d, 1'b1, 10 + d, 1'b0);
    run_region(2, 7, 1'b0, 7, 1'b1);    // R9 R11 disturbed run
    t_illegal(12, 1);
    t_illegal(0, 1);
    t_illegal(5, 0);
    t_illegal(5, 5);
    run_region(1, 6, 1'b1, 8, 1'b0);    // R9: ignored starts left pointer alone
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule